// File: doc/BRIEF.md
# Lockstep SIMD Lane Processing Element

This block is one lane of a lockstep SIMD array. A central controller broadcasts one instruction per cycle to every lane; each lane applies it to its own state and to a private local memory of 2048 words of 64 bits. The lane uses a one-address form: the instruction names one operand, and the other operand and usual destination is the accumulator. Besides the accumulator the lane keeps an operand buffer, a scratch register, an 11-bit index register that offsets every memory address, and a routing register whose contents leave the lane and which can capture data arriving from a neighbour.

Every operation has a fixed latency that does not depend on operand values. Nothing is ever returned to the controller: no ready, done or status signal exists. A lane-enable input masks the lane. A masked lane ignores the broadcast instruction's writes but stays in step with the array. Integer add and subtract can run as one 64-bit lane, as two 32-bit halves or as eight 8-bit sub-lanes. No carry or borrow crosses from one sub-lane into the next.

Top module: `simd_lane_pe`

## Requirements
- R1: While `rst_n` is low at a rising edge, the accumulator, buffer, scratch, routing and index registers clear to zero, so `acc_out` and `route_out` read zero.
- R2: Opcode 3 (load immediate) writes `ins_imm` into the accumulator at the first rising edge after issue.
- R3: Opcode 2 (store) writes the accumulator to memory word (X + `ins_addr`) at the issue edge. Opcode 1 (load) reads that word; the accumulator takes the value at the second rising edge after issue. All other opcodes complete at the first edge.
- R4: The effective address X + `ins_addr` wraps modulo 2048. Opcode 13 sets X to `ins_imm[10:0]`.
- R5: With `ins_mode` = 0, opcode 6 adds and opcode 7 subtracts (accumulator minus operand) over the full 64 bits, modulo 2^64.
- R6: With `ins_mode` = 1, add and subtract operate on bits 31:0 and 63:32 separately; no carry or borrow crosses bit 32.
- R7: With `ins_mode` = 2, add and subtract operate on eight independent 8-bit fields; no carry or borrow crosses a byte boundary. `ins_mode` = 3 behaves as mode 0.
- R8: Opcodes 8, 9 and 10 put the bitwise AND, OR and XOR of the accumulator and the operand into the accumulator, whatever the mode.
- R9: For opcodes 6 to 10 the operand is `ins_imm` when `ins_addr[10]` is 1. When `ins_addr[10]` is 0, the operand is the register that `ins_addr[1:0]` selects: 0 buffer, 1 scratch, 2 routing, 3 index (zero-extended).
- R10: Opcode 4 copies the accumulator into the register selected by `ins_addr[1:0]` (index takes its low 11 bits). Opcode 5 copies the selected register into the accumulator.
- R11: `route_out` always shows the routing register. Opcode 11 copies the accumulator into it. Opcode 12 captures `route_in` into it at the issue edge. Neither changes the accumulator.
- R12: An instruction issued with `lane_en` low changes no register and no memory word. A load issued while disabled never writes the accumulator.
- R13: When a load completes in the same cycle as the following instruction writes the accumulator, the following instruction's result wins. That instruction reads the accumulator value from before the load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Array clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lane_en | input | 1 | Lane mask for the instruction issued this cycle |
| ins_valid | input | 1 | Broadcast instruction present this cycle |
| ins_op | input | 4 | Opcode |
| ins_mode | input | 2 | Partition mode for add and subtract |
| ins_addr | input | 11 | Memory offset, or register select and immediate flag |
| ins_imm | input | 64 | Broadcast immediate constant |
| route_in | input | 64 | Data arriving from the neighbouring lane |
| route_out | output | 64 | Routing register contents |
| acc_out | output | 64 | Accumulator contents |

## Verification
A load's write-back lands one cycle after its issue edge. The controller may issue a new instruction in that same cycle, and it may also write the accumulator. The bench provokes this by issuing a load, then at once a load-immediate or an add with an immediate operand, with no idle cycle between them. The accumulator must end up holding the newer instruction's result, and the add must have used the accumulator value from before the load. This shows the two write paths are ordered by program order and not by arrival.

// File: rtl/lane_pkg.sv
package lane_pkg;

  localparam int LANE_W  = 64;
  localparam int SLICE_W = 8;
  localparam int N_SLICE = LANE_W / SLICE_W;
  localparam int HALF_SLICE = N_SLICE / 2;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_LDA   = 4'd1,
    OP_STA   = 4'd2,
    OP_LDI   = 4'd3,
    OP_PUT   = 4'd4,
    OP_GET   = 4'd5,
    OP_ADD   = 4'd6,
    OP_SUB   = 4'd7,
    OP_AND   = 4'd8,
    OP_OR    = 4'd9,
    OP_XOR   = 4'd10,
    OP_ROUTE = 4'd11,
    OP_RECV  = 4'd12,
    OP_SETX  = 4'd13
  } lane_op_e;

  typedef enum logic [1:0] {
    PM_FULL  = 2'd0,
    PM_HALF  = 2'd1,
    PM_BYTE  = 2'd2,
    PM_RSVD  = 2'd3
  } part_mode_e;

  // Slice-wise ripple: each slice restarts its carry at a partition edge.
  function automatic logic [LANE_W-1:0] part_addsub(
    input logic [LANE_W-1:0] a,
    input logic [LANE_W-1:0] b,
    input part_mode_e        mode,
    input logic              sub
  );
    logic [LANE_W-1:0]  bb;
    logic [LANE_W-1:0]  res;
    logic [SLICE_W:0]   sum;
    logic               cy;
    bb  = sub ? ~b : b;
    res = '0;
    cy  = sub;
    for (int i = 0; i < N_SLICE; i++) begin
      if (i == 0 || mode == PM_BYTE || (mode == PM_HALF && i == HALF_SLICE))
        cy = sub;
      sum = {1'b0, a[i*SLICE_W +: SLICE_W]} + {1'b0, bb[i*SLICE_W +: SLICE_W]}
            + {{SLICE_W{1'b0}}, cy};
      res[i*SLICE_W +: SLICE_W] = sum[SLICE_W-1:0];
      cy = sum[SLICE_W];
    end
    return res;
  endfunction

endpackage

// File: rtl/lane_mem.sv
module lane_mem #(
  parameter int DW    = 64,
  parameter int WORDS = 2048,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [WORDS];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
    rdata <= cells[addr];
  end
endmodule

// File: rtl/lane_alu.sv
module lane_alu
  import lane_pkg::*;
#(
  parameter int DW = LANE_W
) (
  input  lane_op_e      op,
  input  part_mode_e    mode,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] opnd,
  output logic [DW-1:0] result
);
  always_comb begin
    unique case (op)
      OP_ADD:  result = part_addsub(acc, opnd, mode, 1'b0);
      OP_SUB:  result = part_addsub(acc, opnd, mode, 1'b1);
      OP_AND:  result = acc & opnd;
      OP_OR:   result = acc | opnd;
      OP_XOR:  result = acc ^ opnd;
      default: result = opnd;
    endcase
  end
endmodule

// File: rtl/simd_lane_pe.sv
module simd_lane_pe
  import lane_pkg::*;
#(
  parameter int DW        = LANE_W,
  parameter int MEM_WORDS = 2048,
  localparam int AW       = $clog2(MEM_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lane_en,
  input  logic          ins_valid,
  input  logic [3:0]    ins_op,
  input  logic [1:0]    ins_mode,
  input  logic [AW-1:0] ins_addr,
  input  logic [DW-1:0] ins_imm,
  input  logic [DW-1:0] route_in,
  output logic [DW-1:0] route_out,
  output logic [DW-1:0] acc_out
);
  logic [DW-1:0] acc_q, buf_q, scr_q, rte_q;
  logic [AW-1:0] idx_q;

  lane_op_e      op;
  part_mode_e    mode;
  logic          issue_en;
  logic          a_wr_now;
  logic          ld_done;
  logic          mem_we;
  logic [AW-1:0] eff_addr;
  logic [DW-1:0] mem_rd;
  logic [DW-1:0] sel_reg;
  logic [DW-1:0] opnd;
  logic [DW-1:0] alu_res;
  logic [DW-1:0] a_new;

  assign op       = lane_op_e'(ins_op);
  assign mode     = part_mode_e'(ins_mode);
  assign issue_en = ins_valid && lane_en;
  assign eff_addr = idx_q + ins_addr;
  assign mem_we   = issue_en && (op == OP_STA);

  always_comb begin
    unique case (ins_addr[1:0])
      2'd0:    sel_reg = buf_q;
      2'd1:    sel_reg = scr_q;
      2'd2:    sel_reg = rte_q;
      default: sel_reg = {{(DW-AW){1'b0}}, idx_q};
    endcase
  end

  assign opnd = ins_addr[AW-1] ? ins_imm : sel_reg;

  lane_alu #(.DW(DW)) u_alu (
    .op     (op),
    .mode   (mode),
    .acc    (acc_q),
    .opnd   (opnd),
    .result (alu_res)
  );

  lane_mem #(.DW(DW), .WORDS(MEM_WORDS)) u_mem (
    .clk   (clk),
    .addr  (eff_addr),
    .we    (mem_we),
    .wdata (acc_q),
    .rdata (mem_rd)
  );

  always_comb begin
    a_wr_now = 1'b0;
    a_new    = acc_q;
    if (issue_en) begin
      unique case (op)
        OP_LDI: begin a_wr_now = 1'b1; a_new = ins_imm; end
        OP_GET: begin a_wr_now = 1'b1; a_new = sel_reg; end
        OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR:
                begin a_wr_now = 1'b1; a_new = alu_res; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      buf_q   <= '0;
      scr_q   <= '0;
      rte_q   <= '0;
      idx_q   <= '0;
      ld_done <= 1'b0;
    end else begin
      ld_done <= issue_en && (op == OP_LDA);
      if (a_wr_now)     acc_q <= a_new;
      else if (ld_done) acc_q <= mem_rd;
      if (issue_en) begin
        unique case (op)
          OP_PUT: begin
            unique case (ins_addr[1:0])
              2'd0:    buf_q <= acc_q;
              2'd1:    scr_q <= acc_q;
              2'd2:    rte_q <= acc_q;
              default: idx_q <= acc_q[AW-1:0];
            endcase
          end
          OP_ROUTE: rte_q <= acc_q;
          OP_RECV:  rte_q <= route_in;
          OP_SETX:  idx_q <= ins_imm[AW-1:0];
          default: ;
        endcase
      end
    end
  end

  assign acc_out   = acc_q;
  assign route_out = rte_q;
endmodule

// File: rtl/lane_pe_chk.sv
module lane_pe_chk
  import lane_pkg::*;
#(
  parameter int DW = 64,
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lane_en,
  input logic          ins_valid,
  input logic [3:0]    ins_op,
  input logic [DW-1:0] ins_imm,
  input logic [DW-1:0] route_in,
  input logic [DW-1:0] route_out,
  input logic [DW-1:0] acc_out,
  input logic          ld_done,
  input logic          a_wr_now,
  input logic          mem_we,
  input logic [DW-1:0] mem_rd,
  input logic [AW-1:0] eff_addr
);
  logic act;
  assign act = ins_valid && lane_en;

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (acc_out == '0 && route_out == '0));

  a_r2_ldi_value: assert property (@(posedge clk) disable iff (!rst_n)
    (act && ins_op == OP_LDI) |=> acc_out == $past(ins_imm));

  a_r3_load_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (act && ins_op == OP_LDA) |=> ld_done);

  a_r3_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_done && !a_wr_now) |=> acc_out == $past(mem_rd));

  a_r11_route_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (act && ins_op == OP_ROUTE) |=> route_out == $past(acc_out));

  a_r11_recv_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (act && ins_op == OP_RECV) |=> route_out == $past(route_in));

  a_r12_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !lane_en && !ld_done) |=> ($stable(acc_out) && $stable(route_out)));

  a_r12_masked_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    !lane_en |-> !mem_we);

  a_r13_newer_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_done && act && ins_op == OP_LDI) |=> acc_out == $past(ins_imm));

  a_r4_addr_known: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !$isunknown(eff_addr));
endmodule

bind simd_lane_pe lane_pe_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lane_en   (lane_en),
  .ins_valid (ins_valid),
  .ins_op    (ins_op),
  .ins_imm   (ins_imm),
  .route_in  (route_in),
  .route_out (route_out),
  .acc_out   (acc_out),
  .ld_done   (ld_done),
  .a_wr_now  (a_wr_now),
  .mem_we    (mem_we),
  .mem_rd    (mem_rd),
  .eff_addr  (eff_addr)
);

// File: tb/simd_lane_pe_tb.sv
module simd_lane_pe_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lane_en;
  logic        ins_valid;
  logic [3:0]  ins_op;
  logic [1:0]  ins_mode;
  logic [10:0] ins_addr;
  logic [63:0] ins_imm;
  logic [63:0] route_in;
  logic [63:0] route_out;
  logic [63:0] acc_out;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;

  localparam logic [10:0] IMM = 11'h400;

  simd_lane_pe u_dut (
    .clk(clk), .rst_n(rst_n), .lane_en(lane_en), .ins_valid(ins_valid),
    .ins_op(ins_op), .ins_mode(ins_mode), .ins_addr(ins_addr),
    .ins_imm(ins_imm), .route_in(route_in), .route_out(route_out),
    .acc_out(acc_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WATCHDOG) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual=%0d cycles expected<%0d", cycles, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  // Independent reference: split by field width and use native arithmetic.
  function automatic logic [63:0] ref_arith(input logic [63:0] a, input logic [63:0] b,
                                             input logic [1:0] md, input logic sub);
    logic [63:0] r;
    if (md == 2'd1) begin
      r[31:0]  = sub ? a[31:0] - b[31:0]   : a[31:0] + b[31:0];
      r[63:32] = sub ? a[63:32] - b[63:32] : a[63:32] + b[63:32];
    end else if (md == 2'd2) begin
      for (int k = 0; k < 8; k++) begin
        logic [7:0] x, y;
        x = a[k*8 +: 8];
        y = b[k*8 +: 8];
        r[k*8 +: 8] = sub ? x - y : x + y;
      end
    end else begin
      r = sub ? a - b : a + b;
    end
    return r;
  endfunction

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [1:0] md, input logic [10:0] ad,
                       input logic [63:0] im, input logic en);
    ins_valid = 1'b1; ins_op = op; ins_mode = md; ins_addr = ad;
    ins_imm = im; lane_en = en;
    @(negedge clk);
    ins_valid = 1'b0; lane_en = 1'b1; ins_op = 4'd0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(acc_out, 64'h0, "R1 acc after reset");
    chk(route_out, 64'h0, "R1 route after reset");
    rst_n = 1'b1;
    idle();
  endtask

  task automatic t_ldi();
    issue(4'd3, 2'd0, 11'd0, 64'hDEAD_BEEF_0123_4567, 1'b1);
    chk(acc_out, 64'hDEAD_BEEF_0123_4567, "R2 load immediate");
  endtask

  task automatic t_full();
    issue(4'd3, 2'd0, 11'd0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    issue(4'd6, 2'd0, IMM, 64'd1, 1'b1);
    chk(acc_out, 64'h0, "R5 64-bit add wrap");
    issue(4'd7, 2'd0, IMM, 64'd1, 1'b1);
    chk(acc_out, 64'hFFFF_FFFF_FFFF_FFFF, "R5 64-bit sub borrow");
    issue(4'd3, 2'd0, 11'd0, 64'h0000_0000_FFFF_FFFF, 1'b1);
    issue(4'd6, 2'd3, IMM, 64'd1, 1'b1);
    chk(acc_out, 64'h0000_0001_0000_0000, "R7 mode 3 acts as full width");
  endtask

  task automatic t_half();
    issue(4'd3, 2'd0, 11'd0, 64'h0000_0000_FFFF_FFFF, 1'b1);
    issue(4'd6, 2'd1, IMM, 64'd1, 1'b1);
    chk(acc_out, 64'h0, "R6 half add no carry across bit 32");
    issue(4'd3, 2'd0, 11'd0, 64'h0000_0001_0000_0000, 1'b1);
    issue(4'd7, 2'd1, IMM, 64'd1, 1'b1);
    chk(acc_out, 64'h0000_0001_FFFF_FFFF, "R6 half sub no borrow across bit 32");
  endtask

  task automatic t_byte();
    logic [63:0] a = 64'h80FF_7F01_00FF_10FE;
    logic [63:0] b = 64'h8001_7F01_0101_1003;
    issue(4'd3, 2'd0, 11'd0, a, 1'b1);
    issue(4'd6, 2'd2, IMM, b, 1'b1);
    chk(acc_out, ref_arith(a, b, 2'd2, 1'b0), "R7 byte add");
    issue(4'd3, 2'd0, 11'd0, a, 1'b1);
    issue(4'd7, 2'd2, IMM, b, 1'b1);
    chk(acc_out, ref_arith(a, b, 2'd2, 1'b1), "R7 byte sub");
  endtask

  task automatic t_logic();
    logic [63:0] a = 64'hF0F0_1234_AAAA_0F0F;
    logic [63:0] b = 64'h0FF0_FFFF_5555_00FF;
    issue(4'd3, 2'd0, 11'd0, a, 1'b1);
    issue(4'd8, 2'd2, IMM, b, 1'b1);
    chk(acc_out, a & b, "R8 AND");
    issue(4'd9, 2'd1, IMM, b, 1'b1);
    chk(acc_out, (a & b) | b, "R8 OR");
    issue(4'd10, 2'd0, IMM, a, 1'b1);
    chk(acc_out, ((a & b) | b) ^ a, "R8 XOR");
  endtask

  task automatic t_moves();
    issue(4'd3, 2'd0, 11'd0, 64'h0000_0000_0000_0100, 1'b1);
    issue(4'd4, 2'd0, 11'd0, 64'h0, 1'b1);            // buffer <- A
    issue(4'd3, 2'd0, 11'd0, 64'h1111_2222_3333_4444, 1'b1);
    issue(4'd4, 2'd0, 11'd1, 64'h0, 1'b1);            // scratch <- A
    issue(4'd3, 2'd0, 11'd0, 64'h0000_0000_0000_0023, 1'b1);
    issue(4'd6, 2'd0, 11'd0, 64'hFFFF, 1'b1);         // A + buffer, imm ignored
    chk(acc_out, 64'h0000_0000_0000_0123, "R9 register operand selected");
    issue(4'd5, 2'd0, 11'd1, 64'h0, 1'b1);
    chk(acc_out, 64'h1111_2222_3333_4444, "R10 get scratch");
    issue(4'd3, 2'd0, 11'd0, 64'hFFFF_0000_0000_0705, 1'b1);
    issue(4'd4, 2'd0, 11'd3, 64'h0, 1'b1);            // X <- A[10:0]
    issue(4'd5, 2'd0, 11'd3, 64'h0, 1'b1);
    chk(acc_out, 64'h0000_0000_0000_0705, "R10 index round trip");
    issue(4'd13, 2'd0, 11'd0, 64'h0, 1'b1);
  endtask

  task automatic t_route();
    issue(4'd3, 2'd0, 11'd0, 64'hCAFE_F00D_1234_5678, 1'b1);
    issue(4'd11, 2'd0, 11'd0, 64'h0, 1'b1);
    chk(route_out, 64'hCAFE_F00D_1234_5678, "R11 route copies A");
    route_in = 64'h0BAD_0BAD_0BAD_0BAD;
    issue(4'd12, 2'd0, 11'd0, 64'h0, 1'b1);
    route_in = 64'h0;
    chk(route_out, 64'h0BAD_0BAD_0BAD_0BAD, "R11 receive latches input");
    chk(acc_out, 64'hCAFE_F00D_1234_5678, "R11 receive leaves A");
  endtask

  task automatic t_mem();
    issue(4'd13, 2'd0, 11'd0, 64'h7FE, 1'b1);
    issue(4'd3, 2'd0, 11'd0, 64'h5A5A_0000_1111_2222, 1'b1);
    issue(4'd2, 2'd0, 11'd5, 64'h0, 1'b1);            // word (0x7FE+5)%2048 = 3
    issue(4'd13, 2'd0, 11'd0, 64'h0, 1'b1);
    issue(4'd3, 2'd0, 11'd0, 64'h0, 1'b1);
    issue(4'd1, 2'd0, 11'd3, 64'h0, 1'b1);
    chk(acc_out, 64'h0, "R3 load not visible after one edge");
    idle();
    chk(acc_out, 64'h5A5A_0000_1111_2222, "R4 wrapped address load");
  endtask

  task automatic t_disable();
    issue(4'd3, 2'd0, 11'd0, 64'h0000_0000_0000_0077, 1'b1);
    issue(4'd2, 2'd0, 11'd9, 64'h0, 1'b1);
    issue(4'd3, 2'd0, 11'd0, 64'h0000_0000_0000_0088, 1'b1);
    issue(4'd2, 2'd0, 11'd9, 64'h0, 1'b0);            // masked store
    issue(4'd3, 2'd0, 11'd0, 64'h1234, 1'b0);         // masked load immediate
    chk(acc_out, 64'h0000_0000_0000_0088, "R12 masked LDI ignored");
    issue(4'd1, 2'd0, 11'd9, 64'h0, 1'b0);            // masked load
    idle();
    chk(acc_out, 64'h0000_0000_0000_0088, "R12 masked load ignored");
    issue(4'd11, 2'd0, 11'd0, 64'h0, 1'b0);
    chk(route_out, 64'h0BAD_0BAD_0BAD_0BAD, "R12 masked route ignored");
    issue(4'd1, 2'd0, 11'd9, 64'h0, 1'b1);
    idle();
    chk(acc_out, 64'h0000_0000_0000_0077, "R12 masked store ignored");
  endtask

  task automatic t_collide();
    issue(4'd3, 2'd0, 11'd0, 64'h0000_0000_0000_0010, 1'b1);
    issue(4'd1, 2'd0, 11'd3, 64'h0, 1'b1);
    issue(4'd3, 2'd0, 11'd0, 64'h0000_0000_0000_00C0, 1'b1);
    chk(acc_out, 64'h0000_0000_0000_00C0, "R13 newer LDI beats load");
    idle();
    chk(acc_out, 64'h0000_0000_0000_00C0, "R13 value holds");
    issue(4'd3, 2'd0, 11'd0, 64'h0000_0000_0000_0010, 1'b1);
    issue(4'd1, 2'd0, 11'd3, 64'h0, 1'b1);
    issue(4'd6, 2'd0, IMM, 64'd1, 1'b1);
    chk(acc_out, 64'h0000_0000_0000_0011, "R13 add uses pre-load A and wins");
  endtask

  initial begin
    rst_n = 1'b0; lane_en = 1'b1; ins_valid = 1'b0; ins_op = 4'd0;
    ins_mode = 2'd0; ins_addr = 11'd0; ins_imm = 64'h0; route_in = 64'h0;
    @(negedge clk);
    t_reset();
    t_ldi();
    t_full();
    t_half();
    t_byte();
    t_logic();
    t_moves();
    t_route();
    t_mem();
    t_disable();
    t_collide();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule